// File: doc/BRIEF.md
# Bitplane Block Decoder

This block turns one 32-bit compressed word back into a 4x2 block of eight 8-bit pixels. It accepts one word per clock and presents the rebuilt block one cycle later, so a downstream consumer reading four pixels per cycle never waits on it. Each word carries a two-bit mode, a two-bit start plane, a two-bit decision per 2x2 half and twelve bits of coded data per half.

Each pixel is rebuilt from the most significant bit down, in three parts. The upper planes above the start plane are not stored: the mode gives their value, and that value is the same for every pixel in the block. Next come the coded planes. For each half these come either from a fixed table of eight 2x2 patterns, chosen by the half's decision, or from bits stored directly in the word. The planes below the coded ones are filled with a midpoint value of a one followed by zeros. The two halves share the mode and start plane but are decoded independently.

The block sits between a frame store and a consumer of reconstructed pixels. It does no address translation and has no flow control beyond a valid flag.

Top module: `bitplane_block_decoder`

## Requirements
- R1: The word fields are: mode `in_word[31:30]`, start plane `in_word[29:28]`, left decision `[27:26]`, right decision `[25:24]`, left code `[23:12]`, right code `[11:0]`.
- R2: `out_valid` equals the value `in_valid` had one rising edge earlier, and a new word is accepted on every cycle.
- R3: When `in_valid` is low, `out_pix` keeps its previous value.
- R4: While `rst_n` is low at a rising edge, `out_pix` and `out_valid` become zero.
- R5: For start plane S, pixel bits 7 down to 8-S are implied for all eight pixels. Bit 7 is mode[1], bit 6 is mode[0] and bit 5 is 0.
- R6: Decisions 0, 1 and 2 select one of three 8-entry pattern tables, written as hex nibbles by index 0..7. Decision 0: 0,F,E,7,3,C,1,8. Decision 1: 0,F,E,7,A,9,6,5. Decision 2: 0,F,E,7,D,B,2,4.
- R7: With a pattern decision, the half's code holds four 3-bit indices. Index k sits at code bits [11-3k -: 3] and rebuilds pixel bit 7-S-k.
- R8: With decision 3, the half's code holds three raw 4-bit plane nibbles. Nibble k sits at code bits [11-4k -: 4] and rebuilds pixel bit 7-S-k.
- R9: Let L be the lowest coded bit position, which is 4-S for patterns and 5-S for raw planes. Bit L-1 of every pixel is 1 and all bits below it are 0.
- R10: Pixel (row r, column c) occupies `out_pix[8*(4r+c) +: 8]`. The left half covers columns 0-1 and the right half covers columns 2-3. Within a plane nibble, bit 3 is row 0 left, bit 2 is row 0 right, bit 1 is row 1 left and bit 0 is row 1 right.
- R11: Each half is decoded from its own decision and code. A pattern decision on one side and a raw decision on the other decode correctly in the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A compressed word is present this cycle |
| in_word | input | 32 | Compressed block word |
| out_valid | output | 1 | `out_pix` holds a newly rebuilt block |
| out_pix | output | 64 | Eight rebuilt 8-bit pixels |

## Verification
The checker watches four things on every cycle: the one-cycle tracking of the valid flag, the holding of pixels while no word arrives, the implied top plane for any nonzero start plane, and two fill patterns (left-half pattern words at start plane 0, and raw words at start plane 3). Only the bench's scenarios can show the exact table contents, where indices and nibbles sit in the code, the pixel ordering and independent decoding of the two halves. The bench compares every rebuilt block against a model written from the requirements, and adds hand-worked words for the layout and one table lookup.

// File: rtl/bpd_pkg.sv
// Package bpd_pkg
// Shared widths, field layout and pattern tables for the bitplane block
// decoder. Assumes an 8-bit pixel, a 4x2 block and a 32-bit word.
package bpd_pkg;
    localparam int PIX_W      = 8;
    localparam int HALF_PIX   = 4;
    localparam int BLOCK_PIX  = 2 * HALF_PIX;
    localparam int MODE_W     = 2;
    localparam int SP_W       = 2;
    localparam int DEC_W      = 2;
    localparam int IDX_W      = 3;
    localparam int NIB_W      = HALF_PIX;
    localparam int PAT_PLANES = 4;
    localparam int CODE_W     = IDX_W * PAT_PLANES;
    localparam int RAW_PLANES = CODE_W / NIB_W;
    localparam int PREFIX_W   = MODE_W + 1;
    localparam int WORD_W     = MODE_W + SP_W + 2 * DEC_W + 2 * CODE_W;
    localparam int OUT_W      = BLOCK_PIX * PIX_W;
    localparam logic [DEC_W-1:0] DEC_RAW = 2'd3;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [SP_W-1:0]   sp;
        logic [DEC_W-1:0]  dec_l;
        logic [DEC_W-1:0]  dec_r;
        logic [CODE_W-1:0] code_l;
        logic [CODE_W-1:0] code_r;
    } cword_t;

    // Returns the 2x2 plane nibble for a pattern group and index.
    function automatic logic [NIB_W-1:0] pattern_nibble(
        input logic [DEC_W-1:0] grp,
        input logic [IDX_W-1:0] idx
    );
        logic [NIB_W-1:0] r;
        case (idx)
            3'd0: r = 4'h0;
            3'd1: r = 4'hF;
            3'd2: r = 4'hE;
            3'd3: r = 4'h7;
            default: begin
                case ({grp, idx})
                    5'b00_100: r = 4'h3;
                    5'b00_101: r = 4'hC;
                    5'b00_110: r = 4'h1;
                    5'b00_111: r = 4'h8;
                    5'b01_100: r = 4'hA;
                    5'b01_101: r = 4'h9;
                    5'b01_110: r = 4'h6;
                    5'b01_111: r = 4'h5;
                    5'b10_100: r = 4'hD;
                    5'b10_101: r = 4'hB;
                    5'b10_110: r = 4'h2;
                    5'b10_111: r = 4'h4;
                    default:   r = 4'h0;
                endcase
            end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/bpd_plane_source.sv
// Module bpd_plane_source
// Produces the plane nibble for one coded slot of a 2x2 half: either a
// pattern-table lookup of the slot's 3-bit index, or the slot's raw nibble
// when the decision is raw. Slots at or beyond RAW_PLANES exist only for
// pattern decisions; their output is ignored by the caller in raw mode.
module bpd_plane_source
    import bpd_pkg::*;
#(
    parameter int SLOT = 0
) (
    input  logic [DEC_W-1:0]  dec,
    input  logic [CODE_W-1:0] code,
    output logic [NIB_W-1:0]  nib
);
    localparam int IDX_TOP = CODE_W - 1 - IDX_W * SLOT;

    logic [IDX_W-1:0] idx;
    logic [NIB_W-1:0] pat_nib;

    // Extract this slot's index and look it up.
    assign idx     = code[IDX_TOP -: IDX_W];
    assign pat_nib = pattern_nibble(dec, idx);

    generate
        if (SLOT < RAW_PLANES) begin : g_raw
            localparam int NIB_TOP = CODE_W - 1 - NIB_W * SLOT;
            // Raw decision takes the stored nibble directly.
            assign nib = (dec == DEC_RAW) ? code[NIB_TOP -: NIB_W] : pat_nib;
        end else begin : g_pat_only
            // Only pattern decisions reach this slot.
            assign nib = pat_nib;
        end
    endgenerate
endmodule

// File: rtl/bpd_half_decoder.sv
// Module bpd_half_decoder
// Rebuilds the four pixels of one 2x2 half. Bits above the start plane
// come from the mode prefix, then the coded planes follow, then a
// midpoint fill (one, then zeros). Pixel q of the half reads nibble bit
// NIB_W-1-q. Purely combinational.
module bpd_half_decoder
    import bpd_pkg::*;
(
    input  logic [MODE_W-1:0]         mode,
    input  logic [SP_W-1:0]           sp,
    input  logic [DEC_W-1:0]          dec,
    input  logic [CODE_W-1:0]         code,
    output logic [HALF_PIX*PIX_W-1:0] pix
);
    logic [NIB_W-1:0]    slot_nib [PAT_PLANES];
    logic [PREFIX_W-1:0] prefix;
    int                  n_planes;

    // One plane source per coded slot.
    generate
        for (genvar s = 0; s < PAT_PLANES; s++) begin : g_slot
            bpd_plane_source #(.SLOT(s)) u_src (
                .dec  (dec),
                .code (code),
                .nib  (slot_nib[s])
            );
        end
    endgenerate

    // Implied top planes and number of coded planes.
    assign prefix   = {mode, 1'b0};
    assign n_planes = (dec == DEC_RAW) ? RAW_PLANES : PAT_PLANES;

    // Assemble each pixel bit from prefix, coded plane or fill.
    always_comb begin
        pix = '0;
        for (int q = 0; q < HALF_PIX; q++) begin
            for (int b = 0; b < PIX_W; b++) begin
                int         d;
                int         k;
                logic [1:0] kk;
                logic [1:0] pidx;
                logic [1:0] qb;
                logic       bitv;
                d    = PIX_W - 1 - b;
                k    = d - int'(sp);
                kk   = k[1:0];
                pidx = 2'(PREFIX_W - 1 - d);
                qb   = 2'(NIB_W - 1 - q);
                if (d < int'(sp)) begin
                    bitv = prefix[pidx];
                end else if (k < n_planes) begin
                    bitv = slot_nib[kk][qb];
                end else begin
                    bitv = (k == n_planes);
                end
                pix[q*PIX_W + b] = bitv;
            end
        end
    end
endmodule

// File: rtl/bitplane_block_decoder.sv
// Module bitplane_block_decoder
// Top of the decoder: splits the word into its fields, decodes both
// halves in parallel and registers the 4x2 block with one cycle of
// latency. Synchronous active-low reset clears the outputs. The pixel
// register only loads when in_valid is high.
module bitplane_block_decoder
    import bpd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_pix
);
    localparam int HALF_COLS = HALF_PIX / 2;
    localparam int ROW_PIX   = BLOCK_PIX / 2;

    cword_t                    fields;
    logic [HALF_PIX*PIX_W-1:0] half_pix [2];
    logic [DEC_W-1:0]          half_dec [2];
    logic [CODE_W-1:0]         half_code [2];
    logic [OUT_W-1:0]          block_pix;

    // Field split and per-half selection.
    assign fields       = cword_t'(in_word);
    assign half_dec[0]  = fields.dec_l;
    assign half_dec[1]  = fields.dec_r;
    assign half_code[0] = fields.code_l;
    assign half_code[1] = fields.code_r;

    generate
        for (genvar h = 0; h < 2; h++) begin : g_half
            bpd_half_decoder u_half (
                .mode (fields.mode),
                .sp   (fields.sp),
                .dec  (half_dec[h]),
                .code (half_code[h]),
                .pix  (half_pix[h])
            );
            // Place half pixel q at row q/2, column 2h + q%2.
            for (genvar q = 0; q < HALF_PIX; q++) begin : g_place
                localparam int POS = (q / HALF_COLS) * ROW_PIX + h * HALF_COLS + (q % HALF_COLS);
                assign block_pix[POS*PIX_W +: PIX_W] = half_pix[h][q*PIX_W +: PIX_W];
            end
        end
    endgenerate

    // Output register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_pix <= block_pix;
            end
        end
    end
endmodule

// File: rtl/bpd_checker.sv
// Module bpd_checker
// Cycle-by-cycle properties of the decoder, attached by bind.
module bpd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_word,
    input logic        out_valid,
    input logic [63:0] out_pix
);
    logic [7:0] top_bits;
    logic [7:0] b5_bits;
    logic [7:0] left_lo4;
    logic [7:0] all_lo2;

    // Gather cross-pixel bit slices.
    always_comb begin
        for (int p = 0; p < 8; p++) begin
            top_bits[p] = out_pix[8*p + 7];
            b5_bits[p]  = out_pix[8*p + 5];
        end
        left_lo4 = {out_pix[3:0], out_pix[11:8]} & {out_pix[35:32], out_pix[43:40]};
        all_lo2  = {out_pix[1:0], out_pix[9:8], out_pix[33:32], out_pix[41:40]};
    end

    AST_VALID_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                            // R2
    AST_VALID_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                          // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_pix));                                    // R3
    AST_TOP_PLANE_IMPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[29:28] != 2'd0) |=> (top_bits == {8{$past(in_word[31])}})); // R5
    AST_B5_CLEAR_SP3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[29:28] == 2'd3) |=> (b5_bits == 8'h00));      // R5
    AST_FILL_PATTERN_SP0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[29:28] == 2'd0 && in_word[27:26] != 2'd3)
        |=> (left_lo4 == 8'h88 && {out_pix[3:0], out_pix[43:40]} == 8'h88)); // R9
    AST_FILL_RAW_SP3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[29:28] == 2'd3 && in_word[27:24] == 4'hF)
        |=> (all_lo2 == 8'hAA));                                            // R9
endmodule

bind bitplane_block_decoder bpd_checker i_bpd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_pix   (out_pix)
);

// File: tb/test_bitplane_block_decoder.sv
// Directed bench for bitplane_block_decoder, one task per scenario.
module test_bitplane_block_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic [63:0] out_pix;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    bitplane_block_decoder i_bitplane_block_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    // Pattern tables per R6, indexed [group][index].
    function automatic logic [3:0] tbl(input int g, input int i);
        logic [3:0] ta [8] = '{4'h0, 4'hF, 4'hE, 4'h7, 4'h3, 4'hC, 4'h1, 4'h8};
        logic [3:0] tb [8] = '{4'h0, 4'hF, 4'hE, 4'h7, 4'hA, 4'h9, 4'h6, 4'h5};
        logic [3:0] tc [8] = '{4'h0, 4'hF, 4'hE, 4'h7, 4'hD, 4'hB, 4'h2, 4'h4};
        if (g == 0) return ta[i];
        if (g == 1) return tb[i];
        return tc[i];
    endfunction

    // Reference block decode built from R1, R5-R10.
    function automatic logic [63:0] ref_decode(input logic [31:0] w);
        logic [63:0] res = '0;
        int sp = int'(w[29:28]);
        for (int h = 0; h < 2; h++) begin
            logic [3:0]  pl [8];
            logic [1:0]  dec  = h ? w[25:24] : w[27:26];
            logic [11:0] code = h ? w[11:0]  : w[23:12];
            int n;
            int lo;
            for (int b = 0; b < 8; b++) pl[b] = 4'h0;
            if (sp > 0) pl[7] = {4{w[31]}};
            if (sp > 1) pl[6] = {4{w[30]}};
            if (dec == 2'd3) begin
                n = 3;
                for (int k = 0; k < 3; k++) pl[7-sp-k] = code[11-4*k -: 4];
            end else begin
                n = 4;
                for (int k = 0; k < 4; k++) pl[7-sp-k] = tbl(int'(dec), int'(code[11-3*k -: 3]));
            end
            lo = 8 - sp - n;
            if (lo > 0) pl[lo-1] = 4'hF;
            for (int q = 0; q < 4; q++) begin
                int pos = (q / 2) * 4 + (q % 2) + 2 * h;
                for (int b = 0; b < 8; b++) res[8*pos + b] = pl[b][3-q];
            end
        end
        return res;
    endfunction

    task automatic check64(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check1(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive one word, then check the registered result.
    task automatic apply_one(input logic [31:0] w, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
        check1(out_valid, 1'b1, req);
        check64(out_pix, ref_decode(w), req);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check1(out_valid, 1'b0, "R4 reset valid");
        check64(out_pix, 64'h0, "R4 reset pixels");
        rst_n = 1'b1;
    endtask

    task automatic t_layout();
        // Single raw bit at row0/col0 plane 7, sp 0, both halves raw.
        apply_one(32'h0F80_0000, "R10 layout");
        check64(out_pix, 64'h1010_1010_1010_1090, "R10 R1 hand layout");
    endtask

    task automatic t_pattern_hand();
        // Mode 2, sp 2, left group 0 indices 1,2,3,4, right raw zero.
        apply_one(32'hA329_C000, "R7 hand pattern");
        check64(out_pix, 64'h8484_AEBE_8484_BAB2, "R6 R7 hand pattern");
    endtask

    task automatic t_prefix();
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 4; s++)
                apply_one({2'(m), 2'(s), 4'hF, 24'h5A3C96}, "R5 prefix");
    endtask

    task automatic t_groups();
        for (int g = 0; g < 3; g++)
            for (int i = 0; i < 8; i++)
                for (int s = 0; s < 4; s++)
                    apply_one({2'd1, 2'(s), 2'(g), 2'(g),
                               3'(i), 3'((i+1)%8), 3'((i+2)%8), 3'((i+5)%8),
                               3'((i+3)%8), 3'(i), 3'((i+6)%8), 3'((i+7)%8)}, "R6 R7 groups");
    endtask

    task automatic t_raw_fill();
        for (int s = 0; s < 4; s++) begin
            apply_one({2'd3, 2'(s), 4'hF, 12'hC35, 12'h6A9}, "R8 raw");
            apply_one({2'd0, 2'(s), 4'h0, 24'h000000}, "R9 fill pattern");
            apply_one({2'd2, 2'(s), 4'hF, 24'hFFFFFF}, "R9 fill raw");
        end
    endtask

    task automatic t_mixed();
        apply_one({2'd1, 2'd1, 2'd2, 2'd3, 12'h9D3, 12'hA5F}, "R11 mixed");
        apply_one({2'd2, 2'd0, 2'd3, 2'd1, 12'h3C7, 12'h7E1}, "R11 mixed");
    endtask

    task automatic t_hold();
        logic [63:0] held;
        apply_one(32'h6B5E_21C4, "R3 hold setup");
        held = out_pix;
        @(negedge clk);
        in_word = 32'hFFFF_FFFF;
        repeat (2) @(negedge clk);
        check1(out_valid, 1'b0, "R3 idle valid");
        check64(out_pix, held, "R3 hold pixels");
    endtask

    task automatic t_stream();
        logic [31:0] w [6] = '{32'h1234_5678, 32'h9ABC_DEF0, 32'hF00D_BEEF,
                               32'h0FE1_2345, 32'hCAFE_1234, 32'h3F00_0FFF};
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            in_valid = 1'b1;
            in_word  = w[i];
            @(negedge clk);
            check1(out_valid, 1'b1, "R2 stream valid");
            check64(out_pix, ref_decode(w[i]), "R2 stream data");
        end
        in_valid = 1'b0;
        @(negedge clk);
        check1(out_valid, 1'b0, "R2 valid drop");
    endtask

    task automatic t_mid_reset();
        apply_one(32'hDEAD_BEEF, "R4 pre reset");
        rst_n    = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        check1(out_valid, 1'b0, "R4 mid reset valid");
        check64(out_pix, 64'h0, "R4 mid reset pixels");
        in_valid = 1'b0;
        rst_n    = 1'b1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        t_reset();
        t_layout();
        t_pattern_hand();
        t_prefix();
        t_groups();
        t_raw_fill();
        t_mixed();
        t_hold();
        t_stream();
        t_mid_reset();
        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R2 watchdog: actual hung expected done");
            finish_run();
        end
    end
endmodule